// File: doc/BRIEF.md
# ALU Status Flag Generator

This block is the integer arithmetic and logic slice of a datapath. Each cycle it takes two operands, an operation code, an operand size and an incoming carry. It produces a result at the selected width of 8, 16 or 32 bits. It also derives six condition flags from that operation: carry, overflow, sign, zero, auxiliary carry and parity.

The result is combinational. The six flags are held in a register that loads on a rising clock edge only when the flag-write enable is high. A sequencer can therefore run operations that leave the flags alone and still read the last committed condition codes.

Operation codes on `op_i` (3 bits): 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 pass operand A. Size codes on `size_i` (2 bits): 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcodes 0 and 1 give result = A + B (+ `cin_i` for opcode 1 only), truncated to the selected size. The carry flag is set when the unsigned sum does not fit in that size.
- R2: Opcodes 2 and 3 give result = A − B (− `cin_i` for opcode 3 only), truncated to the selected size. The carry flag is set when the unsigned difference is negative (a borrow).
- R3: For opcodes 0–3, the overflow flag is set when the two's-complement result at the selected size falls outside that size's signed range.
- R4: The sign flag equals the most significant bit of the result at the selected size (bit 7, 15 or 31). The zero flag is set when all result bits at the selected size are 0.
- R5: The auxiliary carry flag is set when bits 3..0 produce a carry into bit 4 on an add, or need a borrow from bit 4 on a subtract.
- R6: The parity flag is set when bits 7..0 of the result contain an even number of ones, whatever the size.
- R7: Opcodes 4–7 give A AND B, A OR B, A XOR B and A respectively. For these opcodes carry, overflow and auxiliary carry are 0 and `cin_i` has no effect.
- R8: Result bits above the selected size are 0. Operand bits above the selected size do not affect the result or any flag.
- R9: All six flags load together on a rising clock edge when `flag_we_i` is 1. When it is 0, they keep their values.
- R10: While `rst_n` is low, all six flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size code |
| cin_i | input | 1 | Incoming carry/borrow for opcodes 1 and 3 |
| flag_we_i | input | 1 | Flag register load enable |
| result_o | output | 32 | Result, zero-extended from the selected size |
| cf_o | output | 1 | Registered carry/borrow flag |
| of_o | output | 1 | Registered signed overflow flag |
| sf_o | output | 1 | Registered sign flag |
| zf_o | output | 1 | Registered zero flag |
| af_o | output | 1 | Registered auxiliary carry flag |
| pf_o | output | 1 | Registered parity flag |

## Verification
The adder lanes and the size multiplexer have no hidden state, so a wrong lane selection or carry polarity shows on `result_o` in the same cycle. A flag derived from that wrong result shows on a flag pin one clock later, if the enable was high. A fault in the flag register stays hidden until the enable is low: the held value then drifts from the last committed one, and the bench sees this on the next sampled cycle. The bench keeps its own flag state and compares every pin on every cycle, so a corruption is reported in the cycle it first shows at the ports.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int DATA_W = 32;
  localparam int NLANE  = 3;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
  } flags_t;

  // lane index for a size code: 0 -> 8b, 1 -> 16b, else 32b
  function automatic int unsigned lane_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 0 : (sz == 2'd1) ? 1 : 2;
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (lane_of(sz))
      0:       return DATA_W'(32'h0000_00FF);
      1:       return DATA_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic top_bit(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    case (lane_of(sz))
      0:       return v[7];
      1:       return v[15];
      default: return v[DATA_W-1];
    endcase
  endfunction

  function automatic logic even_ones(input logic [7:0] v);
    return ~^v;
  endfunction

  function automatic logic is_logic_op(input logic [2:0] op);
    return op[2];
  endfunction
endpackage

// File: rtl/alu_arith_core.sv
module alu_arith_core
  import alu_flag_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              aux_o,
  output logic              logic_o
);
  logic              sub_w;
  logic              use_cin_w;
  logic              cx_w;
  logic [DATA_W-1:0] bx_w;
  logic [DATA_W-1:0] logic_res_w;
  logic [DATA_W-1:0] lane_res [NLANE];
  logic [NLANE-1:0]  lane_cout;
  logic [NLANE-1:0]  lane_ovf;
  logic [4:0]        nib_w;
  int unsigned       lane_w;

  assign sub_w     = (op_i == OP_SUB) || (op_i == OP_SBB);
  assign use_cin_w = (op_i == OP_ADC) || (op_i == OP_SBB);
  // subtract as A + ~B + 1, borrow-in lowers the +1
  assign bx_w = sub_w ? ~b_i : b_i;
  assign cx_w = sub_w ? ~(use_cin_w & cin_i) : (use_cin_w & cin_i);

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    localparam int W = 8 << gi;
    logic [W:0] sum;
    logic       c_top;
    assign sum   = {1'b0, a_i[W-1:0]} + {1'b0, bx_w[W-1:0]} + {{W{1'b0}}, cx_w};
    assign c_top = a_i[W-1] ^ bx_w[W-1] ^ sum[W-1];
    assign lane_res[gi]  = DATA_W'(sum[W-1:0]);
    assign lane_cout[gi] = sum[W];
    assign lane_ovf[gi]  = c_top ^ sum[W];
  end

  assign nib_w  = {1'b0, a_i[3:0]} + {1'b0, bx_w[3:0]} + {4'd0, cx_w};
  assign lane_w = lane_of(size_i);

  always_comb begin
    case (op_i)
      OP_AND:  logic_res_w = a_i & b_i;
      OP_OR:   logic_res_w = a_i | b_i;
      OP_XOR:  logic_res_w = a_i ^ b_i;
      default: logic_res_w = a_i;
    endcase
  end

  assign logic_o = is_logic_op(op_i);

  always_comb begin
    if (logic_o) begin
      res_o   = logic_res_w & size_mask(size_i);
      carry_o = 1'b0;
      ovf_o   = 1'b0;
      aux_o   = 1'b0;
    end else begin
      res_o   = lane_res[lane_w];
      carry_o = lane_cout[lane_w] ^ sub_w;
      ovf_o   = lane_ovf[lane_w];
      aux_o   = nib_w[4] ^ sub_w;
    end
  end
endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
  import alu_flag_pkg::*;
(
  input  logic [DATA_W-1:0] res_i,
  input  logic [1:0]        size_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic              aux_i,
  output flags_t            flags_o
);
  always_comb begin
    flags_o.cf = carry_i;
    flags_o.of = ovf_i;
    flags_o.af = aux_i;
    flags_o.sf = top_bit(res_i, size_i);
    flags_o.zf = ((res_i & size_mask(size_i)) == '0);
    flags_o.pf = even_ones(res_i[7:0]);
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  // R9: no enable, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o));
  // R9: enable loads all six flags together
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  input  logic [2:0]  op_i,
  input  logic [1:0]  size_i,
  input  logic        cin_i,
  input  logic        flag_we_i,
  output logic [31:0] result_o,
  output logic        cf_o,
  output logic        of_o,
  output logic        sf_o,
  output logic        zf_o,
  output logic        af_o,
  output logic        pf_o
);
  logic [DATA_W-1:0] core_res_w;
  logic              core_carry_w;
  logic              core_ovf_w;
  logic              core_aux_w;
  logic              core_logic_w;
  flags_t            next_flags_w;
  flags_t            flags_q;

  alu_arith_core u_core (
    .a_i     (opa_i),
    .b_i     (opb_i),
    .op_i    (op_i),
    .size_i  (size_i),
    .cin_i   (cin_i),
    .res_o   (core_res_w),
    .carry_o (core_carry_w),
    .ovf_o   (core_ovf_w),
    .aux_o   (core_aux_w),
    .logic_o (core_logic_w)
  );

  alu_flag_eval u_eval (
    .res_i   (core_res_w),
    .size_i  (size_i),
    .carry_i (core_carry_w),
    .ovf_i   (core_ovf_w),
    .aux_i   (core_aux_w),
    .flags_o (next_flags_w)
  );

  alu_flag_reg u_freg (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (flag_we_i),
    .d_i   (next_flags_w),
    .q_o   (flags_q)
  );

  assign result_o = core_res_w;
  assign cf_o = flags_q.cf;
  assign of_o = flags_q.of;
  assign sf_o = flags_q.sf;
  assign zf_o = flags_q.zf;
  assign af_o = flags_q.af;
  assign pf_o = flags_q.pf;

  // R7: logical class commits cleared carry, overflow, aux carry
  a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && core_logic_w) |=> (!cf_o && !of_o && !af_o));
  // R8: nothing above the selected width
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == 2'd0) |-> (result_o[31:8] == 24'd0));
  // R4: a zero result cannot be negative
  a_r4_zero_not_neg: assert property (@(posedge clk) disable iff (!rst_n)
    zf_o |-> !sf_o);
  // R10: flags clear while held in reset
  always_comb begin
    if (!rst_n) a_r10_reset: assert ({cf_o, of_o, sf_o, zf_o, af_o, pf_o} == 6'd0);
  end
endmodule

// File: tb/alu_flag_unit_tb_top.sv
`timescale 1ns/1ps
module alu_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic        cin_i = 1'b0, flag_we_i = 1'b0;
  logic [31:0] result_o;
  logic        cf_o, of_o, sf_o, zf_o, af_o, pf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit [5:0] exp_f = '0; // {cf,of,sf,zf,af,pf}

  always #2 clk = ~clk; // 250 MHz

  alu_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .opa_i(opa_i), .opb_i(opb_i), .op_i(op_i),
    .size_i(size_i), .cin_i(cin_i), .flag_we_i(flag_we_i), .result_o(result_o),
    .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o), .af_o(af_o), .pf_o(pf_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference built on wide signed integers
  task automatic model(input logic [31:0] a, input logic [31:0] b, input int op,
                       input int sz, input bit c, output longint res, output bit [5:0] f);
    int n;
    longint mask, half, am, bm, full, sa, sb, sfull, ci, nib;
    bit cf, of, af, sf, zf, pf;
    int ones;
    n = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (longint'(1) << n) - 1;
    half = longint'(1) << (n - 1);
    am = longint'(a) & mask;
    bm = longint'(b) & mask;
    sa = (am >= half) ? am - (longint'(1) << n) : am;
    sb = (bm >= half) ? bm - (longint'(1) << n) : bm;
    ci = ((op == 1 || op == 3) && c) ? 1 : 0;
    cf = 0; of = 0; af = 0;
    case (op)
      0, 1: begin
        full = am + bm + ci; res = full & mask; cf = (full > mask);
        sfull = sa + sb + ci; of = (sfull >= half) || (sfull < -half);
        nib = (am & 15) + (bm & 15) + ci; af = (nib > 15);
      end
      2, 3: begin
        full = am - bm - ci; res = full & mask; cf = (full < 0);
        sfull = sa - sb - ci; of = (sfull >= half) || (sfull < -half);
        nib = (am & 15) - (bm & 15) - ci; af = (nib < 0);
      end
      4: res = am & bm;
      5: res = am | bm;
      6: res = am ^ bm;
      default: res = am;
    endcase
    sf = (res >= half);
    zf = (res == 0);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'((res >> i) & 1);
    pf = (ones % 2 == 0);
    f = {cf, of, sf, zf, af, pf};
  endtask

  task automatic step(input logic [31:0] a, input logic [31:0] b, input int op,
                      input int sz, input bit c, input bit we, input string req);
    longint r;
    bit [5:0] f;
    @(negedge clk);
    opa_i = a; opb_i = b; op_i = 3'(op); size_i = 2'(sz); cin_i = c; flag_we_i = we;
    model(a, b, op, sz, c, r, f);
    #1;
    chk({req, " result"}, longint'(result_o), r);
    @(posedge clk);
    if (we) exp_f = f;
    #1;
    if (!we) begin
      chk("R9 flags held", longint'({cf_o, of_o, sf_o, zf_o, af_o, pf_o}), longint'(exp_f));
    end else begin
      chk((op >= 4) ? "R7 cf" : (op >= 2) ? "R2 cf borrow" : "R1 cf", longint'(cf_o), longint'(exp_f[5]));
      chk((op >= 4) ? "R7 of" : "R3 of", longint'(of_o), longint'(exp_f[4]));
      chk("R4 sf", longint'(sf_o), longint'(exp_f[3]));
      chk("R4 zf", longint'(zf_o), longint'(exp_f[2]));
      chk((op >= 4) ? "R7 af" : "R5 af", longint'(af_o), longint'(exp_f[1]));
      chk("R6 pf", longint'(pf_o), longint'(exp_f[0]));
    end
  endtask

  initial begin
    #50000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset flags", longint'({cf_o, of_o, sf_o, zf_o, af_o, pf_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 add corners
    step(32'h7F, 32'h01, 0, 0, 0, 1, "R1 add8 signed wrap");
    step(32'hFF, 32'h01, 0, 0, 0, 1, "R1 add8 carry zero");
    step(32'hFFFE, 32'h0001, 1, 1, 1, 1, "R1 adc16 cin");
    step(32'hFFFF_FFFF, 32'h0, 1, 2, 1, 1, "R1 adc32 carry");
    step(32'h0F, 32'h01, 0, 0, 1, 1, "R1 add ignores cin");
    // R2 subtract corners
    step(32'h0000, 32'h0001, 2, 1, 0, 1, "R2 sub16 borrow");
    step(32'h8000_0000, 32'h1, 2, 2, 0, 1, "R2 sub32 signed overflow");
    step(32'h10, 32'h0F, 3, 0, 1, 1, "R2 sbb8 aux borrow");
    step(32'h05, 32'h05, 3, 0, 0, 1, "R2 sbb8 zero");
    // R3 / R4 sign
    step(32'h7FFF, 32'h7FFF, 0, 1, 0, 1, "R3 add16 overflow");
    step(32'h8000_0000, 32'h8000_0000, 0, 3, 0, 1, "R3 add32 size3");
    // R7 logical clears arith flags after a flag-setting op
    step(32'hFF, 32'h01, 0, 0, 0, 1, "R1 setup carry");
    step(32'hF0F0, 32'h0FF0, 4, 1, 1, 1, "R7 and16");
    step(32'hF0, 32'h0F, 5, 0, 1, 1, "R7 or8");
    step(32'hAAAA_AAAA, 32'hAAAA_AAAA, 6, 2, 0, 1, "R7 xor32 zero");
    step(32'h8123_4503, 32'h0, 7, 2, 1, 1, "R7 pass");
    // R8 upper operand bits ignored
    step(32'hDEAD_BE7F, 32'h1234_5601, 0, 0, 0, 1, "R8 add8 upper ignored");
    step(32'hABCD_0000, 32'h9876_0001, 2, 1, 0, 1, "R8 sub16 upper ignored");
    step(32'hFFFF_FF0F, 32'hFFFF_FF03, 6, 0, 0, 1, "R8 xor8 upper ignored");
    // R9 hold with enable low
    step(32'hFF, 32'hFF, 0, 0, 0, 1, "R1 setup");
    step(32'h0, 32'h0, 4, 0, 0, 0, "R9 no write");
    step(32'h1, 32'h3, 2, 2, 1, 0, "R9 no write sub");
    // R6 parity uses only low byte
    step(32'hFF00, 32'h0003, 5, 1, 0, 1, "R6 parity low byte");
    // random sweep
    for (int k = 0; k < 300; k++) begin
      int op;
      op = $urandom_range(0, 7);
      step($urandom, $urandom, op, $urandom_range(0, 3), 1'($urandom), 1'($urandom_range(0, 3) != 0),
           (op >= 4) ? "R7 random" : (op >= 2) ? "R2 random" : "R1 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule